// File: doc/BRIEF.md
# Macro-instruction micro-op sequencer

The sequencer accepts one decoded macro-instruction at a time on a valid/ready handshake, together with its register and immediate fields, and turns it into a stream of RISC-like micro-ops on a second valid/ready handshake that feeds the rename stage. Instructions that need four micro-ops or fewer are cracked by fixed combinational logic, one micro-op per accepted output beat. Longer instructions load a ROM entry point into a micro-program counter. The counter then steps by one on each accepted beat, and each beat emits the ROM word it points at, until a word flagged as the last one has been emitted.

A micro-op is 24 bits: `{op[23:20], dst[19:16], srcA[15:12], srcB[11:8], imm[7:0]}`. Register codes 0 to 7 are the eight architected integer registers, with code 4 serving as the stack pointer. Codes 8 to 14 are temporaries, and code 15 is the carry flag, which micro-ops read as an ordinary register. Micro-op opcodes are NOP=0, MOV=1 (dst<=srcA), ADD=2 (dst<=srcA+srcB), ADDI=3 (dst<=srcA+sext(imm)), LD=4 (dst<=mem[srcA+imm]) and ST=5 (mem[srcA+imm]<=srcB, dst=0). The macro field `rd` is the destination or base register, `rs` is the source register, and `imm` is the displacement.

While the current instruction is still being emitted, the input is accepted only in the same cycle that its final micro-op is taken. This allows instructions to run back to back with no bubble.

Top module: `uop_seq`

## Requirements
- R1: After reset, `uop_valid_o` is 0 and `instr_ready_o` is 1. Whenever no micro-op is pending, `instr_ready_o` is 1.
- R2: Macro opcode 0 (register move) emits the single micro-op {MOV, rd, rs, 0, 0}. Macro opcode 1 (register add) emits the single micro-op {ADD, rd, rd, rs, 0}.
- R3: Macro opcode 2 (add-with-carry into memory) emits exactly four micro-ops, in this order: {LD, 8, rd, 0, imm}, {ADD, 8, 8, 15, 0}, {ADD, 8, 8, rs, 0}, {ST, 0, rd, 8, imm}.
- R4: Macro opcode 3 (register swap) emits three micro-ops through temporary 8, in this order: {MOV, 8, rd, 0, 0}, {MOV, rd, rs, 0, 0}, {MOV, rs, 8, 0, 0}.
- R5: Macro opcode 4 (push all registers) is sequenced from the ROM and emits 18 micro-ops. The first is {MOV, 9, 4, 0, 0}. Then, for each register i from 0 to 7, it emits {ADDI, 9, 9, 0, 0xFC} followed by {ST, 0, 9, i, 0}. The last is {MOV, 4, 9, 0, 0}.
- R6: Macro opcode 5 (pop all registers) is sequenced from the ROM and emits 9 micro-ops. For i from 7 down to 0, it emits {LD, i, 4, 0, 4*(7-i)}, except that the slot for i=4 is a NOP. The last is {ADDI, 4, 4, 0, 0x20}.
- R7: `uop_last_o` is 1 exactly on the final micro-op of an instruction. While a micro-op is pending, `instr_ready_o` is 1 only when that micro-op is the final one and `uop_ready_i` is 1, so the next instruction is taken in the same cycle with no idle beat.
- R8: While `uop_valid_o` is 1 and `uop_ready_i` is 0, the micro-op, the last flag and the valid flag hold. No micro-op is dropped or repeated.
- R9: Macro opcodes 6 to 15 emit one all-zero NOP micro-op.
- R10: The carry flag is read as register code 15. Temporaries use codes 8 to 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_valid_i | input | 1 | Macro-instruction offered |
| instr_ready_o | output | 1 | Macro-instruction taken this cycle when valid |
| instr_op_i | input | 4 | Decoded macro opcode |
| instr_rd_i | input | 4 | Destination or base register |
| instr_rs_i | input | 4 | Source register |
| instr_imm_i | input | 8 | Displacement |
| uop_valid_o | output | 1 | Micro-op present |
| uop_ready_i | input | 1 | Rename stage takes the micro-op |
| uop_o | output | 24 | Micro-op word |
| uop_last_o | output | 1 | Final micro-op of the instruction |

## Verification
The hardest case to reach is the boundary between two instructions. Here the final micro-op of one instruction, possibly a ROM word, is held by backpressure while the next instruction is already waiting, and the micro-PC must reload rather than step. The bench gets there by driving a long random mix of cracked and ROM-sequenced opcodes with randomly gated input validity and random output stalls. It also runs a directed phase in which every opcode is offered back to back with the output always ready. A behavioural queue model predicts the micro-op, the last flag and both ready/valid signals on every cycle.

// File: rtl/uop_seq_pkg.sv
package uop_seq_pkg;
  localparam int REG_W     = 4;
  localparam int IMM_W     = 8;
  localparam int UOP_OP_W  = 4;
  localparam int MAC_OP_W  = 4;
  localparam int UOP_W     = UOP_OP_W + 3 * REG_W + IMM_W;
  localparam int CRACK_MAX = 4;
  localparam int IDX_W     = $clog2(CRACK_MAX);
  localparam int LEN_W     = IDX_W + 1;

  typedef logic [REG_W-1:0] reg_t;
  typedef logic [IMM_W-1:0] imm_t;

  typedef enum logic [UOP_OP_W-1:0] {
    U_NOP  = 4'd0,
    U_MOV  = 4'd1,
    U_ADD  = 4'd2,
    U_ADDI = 4'd3,
    U_LD   = 4'd4,
    U_ST   = 4'd5
  } uop_op_e;

  typedef enum logic [MAC_OP_W-1:0] {
    M_MOV     = 4'd0,
    M_ADD     = 4'd1,
    M_ADC_MEM = 4'd2,
    M_SWAP    = 4'd3,
    M_PUSHALL = 4'd4,
    M_POPALL  = 4'd5
  } mac_op_e;

  typedef struct packed {
    uop_op_e op;
    reg_t    dst;
    reg_t    src_a;
    reg_t    src_b;
    imm_t    imm;
  } uop_t;

  typedef struct packed {
    logic last;
    uop_t u;
  } rom_word_t;

  localparam reg_t R_SP = 4'd4;
  localparam reg_t R_T0 = 4'd8;
  localparam reg_t R_T1 = 4'd9;
  localparam reg_t R_CF = 4'd15;
  localparam int   NUM_ARCH = 8;

  // ROM layout: push-all then pop-all
  localparam int PUSH_ENTRY = 0;
  localparam int PUSH_LEN   = 2 + 2 * NUM_ARCH;
  localparam int POP_ENTRY  = PUSH_ENTRY + PUSH_LEN;
  localparam int POP_LEN    = NUM_ARCH + 1;
  localparam int ROM_USED   = POP_ENTRY + POP_LEN;

  function automatic uop_t mk_uop(uop_op_e o, reg_t d, reg_t a, reg_t b, imm_t i);
    uop_t r;
    r.op = o; r.dst = d; r.src_a = a; r.src_b = b; r.imm = i;
    return r;
  endfunction

  function automatic logic op_uses_rom(logic [MAC_OP_W-1:0] op);
    return (op == M_PUSHALL) || (op == M_POPALL);
  endfunction

  function automatic int op_entry(logic [MAC_OP_W-1:0] op);
    return (op == M_POPALL) ? POP_ENTRY : PUSH_ENTRY;
  endfunction
endpackage

// File: rtl/uop_crack.sv
module uop_crack
  import uop_seq_pkg::*;
(
  input  logic [MAC_OP_W-1:0] op_i,
  input  reg_t                rd_i,
  input  reg_t                rs_i,
  input  imm_t                imm_i,
  input  logic [IDX_W-1:0]    idx_i,
  output uop_t                uop_o,
  output logic [LEN_W-1:0]    len_o
);
  always_comb begin
    uop_o = mk_uop(U_NOP, '0, '0, '0, '0);
    len_o = LEN_W'(1);
    case (op_i)
      M_MOV: uop_o = mk_uop(U_MOV, rd_i, rs_i, '0, '0);
      M_ADD: uop_o = mk_uop(U_ADD, rd_i, rd_i, rs_i, '0);
      M_ADC_MEM: begin
        len_o = LEN_W'(4);
        case (idx_i)
          2'd0:    uop_o = mk_uop(U_LD,  R_T0, rd_i, '0,   imm_i);
          2'd1:    uop_o = mk_uop(U_ADD, R_T0, R_T0, R_CF, '0);
          2'd2:    uop_o = mk_uop(U_ADD, R_T0, R_T0, rs_i, '0);
          default: uop_o = mk_uop(U_ST,  '0,   rd_i, R_T0, imm_i);
        endcase
      end
      M_SWAP: begin
        len_o = LEN_W'(3);
        case (idx_i)
          2'd0:    uop_o = mk_uop(U_MOV, R_T0, rd_i, '0, '0);
          2'd1:    uop_o = mk_uop(U_MOV, rd_i, rs_i, '0, '0);
          default: uop_o = mk_uop(U_MOV, rs_i, R_T0, '0, '0);
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/uop_rom.sv
module uop_rom
  import uop_seq_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] addr_i,
  output rom_word_t     word_o
);
  localparam int DEPTH = 1 << AW;

  function automatic rom_word_t rom_at(int a);
    rom_word_t w;
    int k;
    int r;
    w.last = 1'b0;
    w.u    = mk_uop(U_NOP, '0, '0, '0, '0);
    if (a == PUSH_ENTRY) begin
      w.u = mk_uop(U_MOV, R_T1, R_SP, '0, '0);
    end else if (a < POP_ENTRY - 1) begin
      k = (a - PUSH_ENTRY - 1) / 2;
      if (((a - PUSH_ENTRY - 1) % 2) == 0)
        w.u = mk_uop(U_ADDI, R_T1, R_T1, '0, 8'hFC);
      else
        w.u = mk_uop(U_ST, '0, R_T1, reg_t'(k), '0);
    end else if (a == POP_ENTRY - 1) begin
      w.u    = mk_uop(U_MOV, R_SP, R_T1, '0, '0);
      w.last = 1'b1;
    end else if (a < ROM_USED - 1) begin
      r = NUM_ARCH - 1 - (a - POP_ENTRY);
      if (r != int'(R_SP))
        w.u = mk_uop(U_LD, reg_t'(r), R_SP, '0, imm_t'(4 * (NUM_ARCH - 1 - r)));
    end else if (a == ROM_USED - 1) begin
      w.u    = mk_uop(U_ADDI, R_SP, R_SP, '0, imm_t'(4 * NUM_ARCH));
      w.last = 1'b1;
    end else begin
      w.last = 1'b1;
    end
    return w;
  endfunction

  rom_word_t rom_arr [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_rom
    assign rom_arr[a] = rom_at(a);
  end

  assign word_o = rom_arr[addr_i];
endmodule

// File: rtl/uop_upc.sv
module uop_upc #(
  parameter int AW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] entry_i,
  input  logic          step_i,
  output logic [AW-1:0] upc_o
);
  logic [AW-1:0] upc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     upc_q <= '0;
    else if (load_i) upc_q <= entry_i;
    else if (step_i) upc_q <= upc_q + 1'b1;
  end

  assign upc_o = upc_q;

  // a new entry point is never loaded while a sequence is still stepping
  p_load_step_excl_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !step_i);
endmodule

// File: rtl/uop_seq.sv
module uop_seq
  import uop_seq_pkg::*;
#(
  parameter int ROM_AW = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                instr_valid_i,
  output logic                instr_ready_o,
  input  logic [MAC_OP_W-1:0] instr_op_i,
  input  logic [REG_W-1:0]    instr_rd_i,
  input  logic [REG_W-1:0]    instr_rs_i,
  input  logic [IMM_W-1:0]    instr_imm_i,
  output logic                uop_valid_o,
  input  logic                uop_ready_i,
  output logic [UOP_W-1:0]    uop_o,
  output logic                uop_last_o
);
  logic                busy_q, rom_q;
  logic [MAC_OP_W-1:0] op_q;
  reg_t                rd_q, rs_q;
  imm_t                imm_q;
  logic [IDX_W-1:0]    idx_q;

  uop_t             crack_uop;
  logic [LEN_W-1:0] crack_len;
  rom_word_t        rom_word;
  logic [ROM_AW-1:0] upc;
  logic             accept, fire, last;

  uop_crack u_crack (
    .op_i  (op_q),
    .rd_i  (rd_q),
    .rs_i  (rs_q),
    .imm_i (imm_q),
    .idx_i (idx_q),
    .uop_o (crack_uop),
    .len_o (crack_len)
  );

  uop_rom #(.AW(ROM_AW)) u_rom (
    .addr_i (upc),
    .word_o (rom_word)
  );

  uop_upc #(.AW(ROM_AW)) u_upc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .entry_i (ROM_AW'(op_entry(instr_op_i))),
    .step_i  (fire && rom_q && !last),
    .upc_o   (upc)
  );

  assign last          = rom_q ? rom_word.last : ({1'b0, idx_q} == crack_len - 1'b1);
  assign fire          = busy_q && uop_ready_i;
  assign instr_ready_o = !busy_q || (uop_ready_i && last);
  assign accept        = instr_valid_i && instr_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rom_q  <= 1'b0;
      op_q   <= '0;
      rd_q   <= '0;
      rs_q   <= '0;
      imm_q  <= '0;
      idx_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      rom_q  <= op_uses_rom(instr_op_i);
      op_q   <= instr_op_i;
      rd_q   <= instr_rd_i;
      rs_q   <= instr_rs_i;
      imm_q  <= instr_imm_i;
      idx_q  <= '0;
    end else if (fire) begin
      if (last) busy_q <= 1'b0;
      else      idx_q  <= idx_q + 1'b1;
    end
  end

  assign uop_valid_o = busy_q;
  assign uop_o       = rom_q ? rom_word.u : crack_uop;
  assign uop_last_o  = busy_q && last;

  always_comb begin
    if (rst_ni && busy_q && !rom_q)
      a_idx_range_r2: assert ({1'b0, idx_q} < crack_len);
  end

  p_idle_ready_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !uop_valid_o |-> instr_ready_o);

  p_accept_at_last_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uop_valid_o && instr_ready_o) |-> (uop_ready_i && uop_last_o));

  p_stall_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uop_valid_o && !uop_ready_i) |=> (uop_valid_o && $stable(uop_o) && $stable(uop_last_o)));
endmodule

// File: tb/tb_uop_seq.sv
module tb_uop_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        instr_valid_i = 1'b0;
  logic        instr_ready_o;
  logic [3:0]  instr_op_i = '0;
  logic [3:0]  instr_rd_i = '0;
  logic [3:0]  instr_rs_i = '0;
  logic [7:0]  instr_imm_i = '0;
  logic        uop_valid_o;
  logic        uop_ready_i = 1'b0;
  logic [23:0] uop_o;
  logic        uop_last_o;

  always #10 clk_i = ~clk_i;

  uop_seq dut (.*);

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [23:0] exp_q [$];
  string       tag_q [$];
  logic [19:0] src_q [$];

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] u(int o, int d, int a, int b, int i);
    return {4'(o), 4'(d), 4'(a), 4'(b), 8'(i)};
  endfunction

  task automatic push(logic [23:0] w, string t);
    exp_q.push_back(w);
    tag_q.push_back(t);
  endtask

  task automatic expand(int op, int rd, int rs, int imm);
    case (op)
      0: push(u(1, rd, rs, 0, 0), "R2");
      1: push(u(2, rd, rd, rs, 0), "R2");
      2: begin
        push(u(4, 8, rd, 0, imm), "R3");
        push(u(2, 8, 8, 15, 0), "R10");
        push(u(2, 8, 8, rs, 0), "R3");
        push(u(5, 0, rd, 8, imm), "R3");
      end
      3: begin
        push(u(1, 8, rd, 0, 0), "R4");
        push(u(1, rd, rs, 0, 0), "R4");
        push(u(1, rs, 8, 0, 0), "R4");
      end
      4: begin
        push(u(1, 9, 4, 0, 0), "R5");
        for (int i = 0; i < 8; i++) begin
          push(u(3, 9, 9, 0, 'hFC), "R5");
          push(u(5, 0, 9, i, 0), "R5");
        end
        push(u(1, 4, 9, 0, 0), "R5");
      end
      5: begin
        for (int i = 7; i >= 0; i--) begin
          if (i == 4) push(u(0, 0, 0, 0, 0), "R6");
          else        push(u(4, i, 4, 0, 4 * (7 - i)), "R6");
        end
        push(u(3, 4, 4, 0, 'h20), "R6");
      end
      default: push(u(0, 0, 0, 0, 0), "R9");
    endcase
  endtask

  task automatic add_src(int op, int rd, int rs, int imm);
    src_q.push_back({4'(op), 4'(rd), 4'(rs), 8'(imm)});
  endtask

  // one cycle: drive at negedge, check, update model
  bit pending = 1'b0;
  bit prev_stall = 1'b0;
  logic [23:0] prev_uop = '0;

  task automatic cycle(bit bp, bit gaps);
    bit exp_rdy;
    bit exp_last;
    @(negedge clk_i);
    uop_ready_i = bp ? (($urandom % 3) != 0) : 1'b1;
    if (!pending && src_q.size() > 0 && (!gaps || ($urandom % 4) != 0)) begin
      logic [19:0] s;
      s = src_q.pop_front();
      {instr_op_i, instr_rd_i, instr_rs_i, instr_imm_i} = s;
      instr_valid_i = 1'b1;
      pending = 1'b1;
    end else if (!pending) begin
      instr_valid_i = 1'b0;
      instr_op_i = 4'($urandom);
    end
    #1;
    chk(uop_valid_o == (exp_q.size() > 0), exp_q.size() > 0 ? tag_q[0] : "R1", "uop_valid", uop_valid_o, exp_q.size() > 0);
    exp_last = (exp_q.size() == 1);
    exp_rdy  = (exp_q.size() == 0) || (uop_ready_i && exp_last);
    chk(instr_ready_o == exp_rdy, "R7", "instr_ready", instr_ready_o, exp_rdy);
    if (exp_q.size() > 0) begin
      chk(uop_o == exp_q[0], tag_q[0], "uop", uop_o, exp_q[0]);
      chk(uop_last_o == exp_last, "R7", "uop_last", uop_last_o, exp_last);
    end
    if (prev_stall) chk(uop_valid_o && uop_o == prev_uop, "R8", "held uop", uop_o, prev_uop);
    prev_stall = uop_valid_o && !uop_ready_i;
    prev_uop   = uop_o;
    if (uop_valid_o && uop_ready_i && exp_q.size() > 0) begin
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
    if (instr_valid_i && instr_ready_o) begin
      expand(instr_op_i, instr_rd_i, instr_rs_i, instr_imm_i);
      pending = 1'b0;
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 60000; c++) begin
      @(posedge clk_i);
      if (done) break;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    void'($urandom(32'h1234_5678));
    #5;
    chk(uop_valid_o == 1'b0, "R1", "reset valid", uop_valid_o, 0);
    chk(instr_ready_o == 1'b1, "R1", "reset ready", instr_ready_o, 1);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // directed, back to back, always ready
    add_src(0, 3, 5, 0);
    add_src(1, 2, 6, 0);
    add_src(2, 1, 7, 'h44);
    add_src(3, 0, 7, 0);
    add_src(4, 0, 0, 0);
    add_src(5, 0, 0, 0);
    add_src(7, 1, 1, 1);
    add_src(15, 2, 2, 2);
    add_src(2, 6, 3, 'h80);
    add_src(4, 0, 0, 0);
    while (src_q.size() > 0 || pending || exp_q.size() > 0) cycle(1'b0, 1'b0);
    // random mix with stalls and gaps
    for (int n = 0; n < 300; n++)
      add_src($urandom % 16 < 10 ? $urandom % 6 : $urandom % 16, $urandom % 8, $urandom % 8, $urandom % 256);
    while (src_q.size() > 0 || pending || exp_q.size() > 0) cycle(1'b1, 1'b1);
    repeat (4) cycle(1'b1, 1'b0);
    done = 1'b1;
    summary();
  end
endmodule